// File: doc/BRIEF.md
# Configurable Serial Shift Interface

This block is a small serial engine for a processor. Its core is one 8-bit shift register that software reads and writes through a four-address register bus. The same register serves a three-wire synchronous link, with separate data-in, data-out and clock pins, and a two-wire link in which data and clock are open-drain lines. Software chooses the shift clock source. It can be a register-write strobe, a timer compare pulse, or the external clock pin sampled on its rising or its falling edge.

A 4-bit counter counts both edges of the chosen clock. When it wraps after 16 edges (one byte), it raises a transfer flag. Output data passes through a transparent hold stage, so the serial output changes on the edge opposite to the one that samples the input. In two-wire mode a hardware detector flags a start condition. After a start condition or a completed byte, the block keeps the clock line low until software clears the matching flag. Both pins pass through two-flop synchronizers before any edge is detected.

Top module: `sshift_engine`

## Requirements
- R1: After reset, all registers read 0. The outputs `so_o`, `sda_drv_low_o`, `scl_drv_low_o`, `irq_xfer_o` and `irq_start_o` are all 0.
- R2: Register addresses are 0 = data, 1 = control, 2 = flags and 3 = counter. A write to address 0 loads the shift register, and a read returns it. If a write and a sampling edge fall in the same cycle, the written value is kept.
- R3: Control bits [1:0] select the clock: 0 = strobe, 1 = timer pulse, 2 = pin with rising-edge sampling, 3 = pin with falling-edge sampling. A strobe is a control write with bit 7 set. On each sampling edge the register shifts left and takes the synchronized `sdi_i` into bit 0. The strobe and timer sources toggle an internal clock level, and a low-to-high toggle samples. A write to address 3 returns that level to low.
- R4: `so_o` follows the register's MSB only in the non-sampling half of the clock. It keeps its value across a sampling edge and takes the new MSB at the opposite edge.
- R5: Control bit 2 selects two-wire mode when set. In three-wire mode `so_o` carries the output bit and `sda_drv_low_o` is 0. In two-wire mode `so_o` is 0 and `sda_drv_low_o` is the inverse of the output bit.
- R6: The counter (flags bits [3:0], or address 3) increments on every edge of the selected clock. An edge at count 15 wraps it to 0 and sets the transfer flag (flags bit 6). A write to address 3 loads the counter.
- R7: In two-wire mode only, a falling data line while the clock line is high sets the start flag (flags bit 7).
- R8: `irq_xfer_o` equals the transfer flag ANDed with control bit 3. `irq_start_o` equals the start flag ANDed with control bit 4.
- R9: In two-wire mode `scl_drv_low_o` is 1 while the start flag or the transfer flag is set.
- R10: Writing 1 to flags bit 6 or bit 7 clears that flag. If a set event falls in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| timer_tick | input | 1 | Timer compare pulse, one cycle |
| sclk_i | input | 1 | Clock pin level (three-wire clock / two-wire clock line) |
| sdi_i | input | 1 | Data pin level (three-wire input / two-wire data line) |
| so_o | output | 1 | Three-wire serial data output |
| sda_drv_low_o | output | 1 | Pull the two-wire data line low |
| scl_drv_low_o | output | 1 | Pull the two-wire clock line low (clock hold) |
| irq_xfer_o | output | 1 | Transfer-complete interrupt |
| irq_start_o | output | 1 | Start-condition interrupt |

## Verification
A software write to the flags or data register can fall in the same cycle as a clock edge that sets the transfer flag or shifts the register. The bench provokes this with the timer source, which needs no synchronizer. With the counter preset to 15, it raises `timer_tick` in the same cycle as a flag-clear write and expects the flag to stay set. In a second case it pairs a tick with a data write and expects the written byte to survive while the counter still advances by one.

// File: rtl/sse_pkg.sv
package sse_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [1:0] {
        CK_SOFT     = 2'd0,
        CK_TIMER    = 2'd1,
        CK_EXT_RISE = 2'd2,
        CK_EXT_FALL = 2'd3
    } ck_src_e;

    typedef enum logic [ADDR_W-1:0] {
        A_DATA  = 2'd0,
        A_CTRL  = 2'd1,
        A_FLAGS = 2'd2,
        A_COUNT = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic    start_ie;
        logic    ovf_ie;
        logic    two_wire;
        ck_src_e src;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/sse_sync.sv
module sse_sync #(
    parameter int   W       = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [1:0] stage_q;
        logic [1:0] stage_d;

        always_comb begin
            stage_d = {stage_q[0], d[i]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= {2{RST_VAL}};
            else        stage_q <= stage_d;
        end

        assign q[i] = stage_q[1];
    end
endmodule

// File: rtl/sse_clk_sel.sv
module sse_clk_sel
    import sse_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  ck_src_e src,
    input  logic    pin_lvl,
    input  logic    soft_stb,
    input  logic    timer_tick,
    input  logic    phase_clr,
    output logic    sample_ev,
    output logic    drive_ev,
    output logic    latch_open
);
    typedef struct packed {
        logic int_lvl;
        logic pin_prev;
    } ck_state_t;

    ck_state_t st_q, st_d;
    logic int_ev, pin_rise, pin_fall;

    always_comb begin
        st_d     = st_q;
        int_ev   = ((src == CK_SOFT) && soft_stb) || ((src == CK_TIMER) && timer_tick);
        pin_rise = pin_lvl && !st_q.pin_prev;
        pin_fall = !pin_lvl && st_q.pin_prev;
        unique case (src)
            CK_EXT_RISE: begin
                sample_ev  = pin_rise;
                drive_ev   = pin_fall;
                latch_open = !pin_lvl;
            end
            CK_EXT_FALL: begin
                sample_ev  = pin_fall;
                drive_ev   = pin_rise;
                latch_open = pin_lvl;
            end
            default: begin
                sample_ev  = int_ev && !st_q.int_lvl;
                drive_ev   = int_ev && st_q.int_lvl;
                latch_open = !st_q.int_lvl;
            end
        endcase
        st_d.pin_prev = pin_lvl;
        if (phase_clr)   st_d.int_lvl = 1'b0;
        else if (int_ev) st_d.int_lvl = !st_q.int_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.int_lvl  <= 1'b0;
            st_q.pin_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // R3
    edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sample_ev, drive_ev}));

    // R3
    int_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ev && !phase_clr) |=> (st_q.int_lvl != $past(st_q.int_lvl)));
endmodule

// File: rtl/sshift_engine.sv
module sshift_engine
    import sse_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              timer_tick,
    input  logic              sclk_i,
    input  logic              sdi_i,
    output logic              so_o,
    output logic              sda_drv_low_o,
    output logic              scl_drv_low_o,
    output logic              irq_xfer_o,
    output logic              irq_start_o
);
    localparam int STB_BIT = DATA_W - 1;
    localparam int ST_BIT  = DATA_W - 1;
    localparam int OV_BIT  = DATA_W - 2;

    typedef struct packed {
        logic [DATA_W-1:0] sr;
        logic              hold;
        logic [CNT_W-1:0]  cnt;
        logic              ovf;
        logic              start;
        ctrl_t             ctrl;
        logic              sda_prev;
    } state_t;

    state_t    state_q, state_d;
    reg_addr_e addr;
    logic      wr_data, wr_ctrl, wr_flags, wr_cnt;
    logic      scl_s, sda_s;
    logic      sample_ev, drive_ev, latch_open;
    logic      lat_out, edge_ev, cnt_wrap, start_ev;

    assign addr     = reg_addr_e'(reg_addr);
    assign wr_data  = reg_wr && (addr == A_DATA);
    assign wr_ctrl  = reg_wr && (addr == A_CTRL);
    assign wr_flags = reg_wr && (addr == A_FLAGS);
    assign wr_cnt   = reg_wr && (addr == A_COUNT);

    sse_sync #(.W(2), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sclk_i, sdi_i}),
        .q     ({scl_s, sda_s})
    );

    sse_clk_sel u_clk (
        .clk        (clk),
        .rst_n      (rst_n),
        .src        (state_q.ctrl.src),
        .pin_lvl    (scl_s),
        .soft_stb   (wr_ctrl && reg_wdata[STB_BIT]),
        .timer_tick (timer_tick),
        .phase_clr  (wr_cnt),
        .sample_ev  (sample_ev),
        .drive_ev   (drive_ev),
        .latch_open (latch_open)
    );

    always_comb begin
        state_d  = state_q;
        lat_out  = latch_open ? state_q.sr[DATA_W-1] : state_q.hold;
        edge_ev  = sample_ev || drive_ev;
        cnt_wrap = edge_ev && (state_q.cnt == '1) && !wr_cnt;
        start_ev = state_q.ctrl.two_wire && state_q.sda_prev && !sda_s && scl_s;

        state_d.hold     = lat_out;
        state_d.sda_prev = sda_s;

        if (sample_ev) state_d.sr = {state_q.sr[DATA_W-2:0], sda_s};
        if (wr_data)   state_d.sr = reg_wdata;

        if (edge_ev) state_d.cnt = state_q.cnt + 1'b1;
        if (wr_cnt)  state_d.cnt = reg_wdata[CNT_W-1:0];

        if (wr_flags && reg_wdata[ST_BIT]) state_d.start = 1'b0;
        if (wr_flags && reg_wdata[OV_BIT]) state_d.ovf   = 1'b0;
        if (cnt_wrap) state_d.ovf   = 1'b1;
        if (start_ev) state_d.start = 1'b1;

        if (wr_ctrl) state_d.ctrl = ctrl_t'(reg_wdata[CTRL_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q          <= '0;
            state_q.sda_prev <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (addr)
            A_DATA:  reg_rdata = state_q.sr;
            A_CTRL:  reg_rdata = DATA_W'(state_q.ctrl);
            A_FLAGS: begin
                reg_rdata[ST_BIT]    = state_q.start;
                reg_rdata[OV_BIT]    = state_q.ovf;
                reg_rdata[CNT_W-1:0] = state_q.cnt;
            end
            default: reg_rdata = DATA_W'(state_q.cnt);
        endcase
    end

    assign so_o          = !state_q.ctrl.two_wire && lat_out;
    assign sda_drv_low_o = state_q.ctrl.two_wire && !lat_out;
    assign scl_drv_low_o = state_q.ctrl.two_wire && (state_q.start || state_q.ovf);
    assign irq_xfer_o    = state_q.ovf && state_q.ctrl.ovf_ie;
    assign irq_start_o   = state_q.start && state_q.ctrl.start_ie;

    // R4
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lat_out) |-> latch_open);

    // R6
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q.cnt != $past(state_q.cnt)) && !$past(wr_cnt))
            |-> (state_q.cnt == CNT_W'($past(state_q.cnt) + 1'b1)));

    // R6
    ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q.ovf) |-> (state_q.cnt == '0));

    // R7
    start_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q.start) |-> $past(state_q.ctrl.two_wire));

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wrap |=> state_q.ovf);

    // R10
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flags && reg_wdata[OV_BIT] && !cnt_wrap) |=> !state_q.ovf);

    // R9
    scl_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(scl_drv_low_o) && !scl_drv_low_o) |-> $past(wr_flags || wr_ctrl));
endmodule

// File: tb/sim_sshift_engine.sv
`timescale 1ns/1ps
module sim_sshift_engine;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       timer_tick = 1'b0;
    logic       m_scl = 1'b0;
    logic       m_sda = 1'b1;
    logic       so_o, sda_drv_low_o, scl_drv_low_o, irq_xfer_o, irq_start_o;
    logic       scl_line, sda_line;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    assign sda_line = m_sda & ~sda_drv_low_o;
    assign scl_line = m_scl & ~scl_drv_low_o;

    sshift_engine u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_addr      (reg_addr),
        .reg_wr        (reg_wr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .timer_tick    (timer_tick),
        .sclk_i        (scl_line),
        .sdi_i         (sda_line),
        .so_o          (so_o),
        .sda_drv_low_o (sda_drv_low_o),
        .scl_drv_low_o (scl_drv_low_o),
        .irq_xfer_o    (irq_xfer_o),
        .irq_start_o   (irq_start_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [7:0] shift_in(input logic [7:0] s, input logic b);
        return {s[6:0], b};
    endfunction

    task automatic chk_out(input string tag, input bit tw, input logic exp);
        if (tw) chk(tag, sda_drv_low_o, !exp);
        else    chk(tag, so_o, exp);
    endtask

    task automatic xfer_ext(input logic [1:0] src, input bit tw, input logic [7:0] ctl,
                            input logic [7:0] d, input logic [7:0] m);
        logic       idle;
        logic [7:0] sr, r;
        logic       so_exp;
        idle = (src == 2'd3);
        m_scl = idle;
        settle(4);
        wr(2'd1, ctl);
        wr(2'd2, 8'hC0);
        wr(2'd3, 8'h00);
        wr(2'd0, d);
        settle(2);
        sr = d; so_exp = d[7];
        chk_out("R4 initial output", tw, so_exp);
        for (int i = 0; i < 8; i++) begin
            m_sda = m[7-i];
            settle(4);
            m_scl = !idle;
            settle(4);
            chk_out("R4 output held across sampling edge", tw, so_exp);
            sr = shift_in(sr, m[7-i]);
            m_scl = idle;
            settle(4);
            so_exp = sr[7];
            chk_out(tw ? "R5 two-wire data drive" : "R4 output after drive edge", tw, so_exp);
        end
        rd(2'd0, r);
        chk("R3 received byte", r, m);
        rd(2'd2, r);
        chk("R6 transfer flag after 16 edges", r[6], 1'b1);
        chk("R6 counter wrapped", r[3:0], 4'h0);
    endtask

    task automatic int_evt(input logic [1:0] src, input logic [7:0] ctl);
        if (src == 2'd0) wr(2'd1, ctl | 8'h80);
        else begin
            @(negedge clk); timer_tick = 1'b1;
            @(negedge clk); timer_tick = 1'b0;
        end
    endtask

    task automatic soft_xfer(input logic [1:0] src, input logic [7:0] d, input logic [7:0] m);
        logic [7:0] ctl, sr, r;
        logic       so_exp;
        ctl = 8'h08 | {6'd0, src};
        wr(2'd1, ctl);
        wr(2'd2, 8'hC0);
        wr(2'd3, 8'h00);
        wr(2'd0, d);
        settle(2);
        sr = d; so_exp = d[7];
        chk("R4 internal-source initial output", so_o, so_exp);
        for (int i = 0; i < 8; i++) begin
            m_sda = m[7-i];
            settle(4);
            int_evt(src, ctl);
            settle(1);
            chk("R4 internal-source hold after sample", so_o, so_exp);
            sr = shift_in(sr, m[7-i]);
            int_evt(src, ctl);
            settle(1);
            so_exp = sr[7];
            chk("R3 internal-source output after drive", so_o, so_exp);
        end
        rd(2'd0, r);
        chk(src == 2'd0 ? "R3 strobe-clocked byte" : "R3 timer-clocked byte", r, m);
        rd(2'd2, r);
        chk("R6 internal-source transfer flag", r[6], 1'b1);
        chk("R8 transfer interrupt", irq_xfer_o, 1'b1);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1-path hung actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] r, d, m;
        logic [1:0] src;
        void'($urandom(32'd1234));
        settle(5);
        rst_n = 1'b1;
        settle(2);

        // R1 reset state
        rd(2'd0, r); chk("R1 data reset", r, 8'h00);
        rd(2'd1, r); chk("R1 control reset", r, 8'h00);
        rd(2'd2, r); chk("R1 flags reset", r, 8'h00);
        chk("R1 outputs reset", {so_o, sda_drv_low_o, scl_drv_low_o, irq_xfer_o, irq_start_o}, 5'b0);

        // R2 direct data access
        wr(2'd0, 8'hA5);
        rd(2'd0, r); chk("R2 data write/read", r, 8'hA5);

        // R3 R4 R6 R8 three-wire random exchanges on both pin edges
        for (int k = 0; k < 4; k++) begin
            src = 2'd2 + 2'($urandom_range(0, 1));
            d = 8'($urandom); m = 8'($urandom);
            xfer_ext(src, 1'b0, 8'h08 | {6'd0, src}, d, m);
            chk("R8 transfer interrupt enabled", irq_xfer_o, 1'b1);
            chk("R9 no clock hold in three-wire", scl_drv_low_o, 1'b0);
        end

        // R3 internal sources
        for (int k = 0; k < 2; k++) begin
            soft_xfer(2'd0, 8'($urandom), 8'($urandom));
            soft_xfer(2'd1, 8'($urandom), 8'($urandom));
        end
        wr(2'd1, 8'h01);
        rd(2'd2, r);
        chk("R8 interrupt masked when disabled", irq_xfer_o, 1'b0);

        // R10 clear and set in the same cycle (timer source, counter at 15)
        wr(2'd2, 8'hC0);
        wr(2'd3, 8'h0F);
        @(negedge clk);
        timer_tick = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h40; reg_wr = 1'b1;
        @(negedge clk);
        timer_tick = 1'b0; reg_wr = 1'b0;
        rd(2'd2, r);
        chk("R10 set wins over same-cycle clear", r[6], 1'b1);
        chk("R6 wrap to zero", r[3:0], 4'h0);
        wr(2'd2, 8'h40);
        rd(2'd2, r);
        chk("R10 write-1 clears transfer flag", r[6], 1'b0);

        // R2 data write wins over a same-cycle sampling edge
        wr(2'd3, 8'h00);
        @(negedge clk);
        timer_tick = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h5A; reg_wr = 1'b1;
        @(negedge clk);
        timer_tick = 1'b0; reg_wr = 1'b0;
        rd(2'd0, r); chk("R2 write beats same-cycle shift", r, 8'h5A);
        rd(2'd3, r); chk("R6 counter advanced by tick", r, 8'h01);

        // R6 counter preset
        wr(2'd3, 8'h0E);
        int_evt(2'd1, 8'h01);
        rd(2'd2, r); chk("R6 preset count 15, no flag", r, 8'h0F);
        int_evt(2'd1, 8'h01);
        rd(2'd2, r); chk("R6 preset overflow after two edges", r, 8'h40);
        wr(2'd2, 8'h40);

        // R7 no start flag in three-wire mode
        wr(2'd1, 8'h02);
        m_sda = 1'b1; m_scl = 1'b1; settle(4);
        m_sda = 1'b0; settle(4);
        rd(2'd2, r); chk("R7 no start in three-wire", r[7], 1'b0);
        m_sda = 1'b1; settle(4);

        // R5 two-wire output drive
        m_scl = 1'b0; settle(4);
        wr(2'd1, 8'h06);
        wr(2'd2, 8'hC0);
        wr(2'd0, 8'h00); settle(2);
        chk("R5 two-wire drives data low for 0", sda_drv_low_o, 1'b1);
        chk("R5 three-wire output quiet in two-wire", so_o, 1'b0);
        wr(2'd0, 8'h80); settle(2);
        chk("R5 two-wire releases data for 1", sda_drv_low_o, 1'b0);

        // R7 R9 start condition and clock hold
        wr(2'd1, 8'h16);
        wr(2'd0, 8'hFF);
        m_sda = 1'b1; m_scl = 1'b1; settle(4);
        wr(2'd2, 8'hC0);
        m_sda = 1'b0; settle(4);
        rd(2'd2, r); chk("R7 start flag set", r[7], 1'b1);
        chk("R9 clock held after start", scl_drv_low_o, 1'b1);
        chk("R8 start interrupt", irq_start_o, 1'b1);
        m_scl = 1'b0; settle(4);
        wr(2'd2, 8'h80); settle(1);
        chk("R10 start flag cleared", irq_start_o, 1'b0);
        chk("R9 clock released after clear", scl_drv_low_o, 1'b0);

        // R5 R9 two-wire byte reception
        m = 8'($urandom);
        xfer_ext(2'd2, 1'b1, 8'h16, 8'hFF, m);
        chk("R9 clock held after byte", scl_drv_low_o, 1'b1);
        wr(2'd2, 8'h40); settle(1);
        chk("R9 clock released after transfer clear", scl_drv_low_o, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule